// File: doc/BRIEF.md
# DMA Channel Status and Interrupt Controller

This block keeps one 32-bit control/status word for each DMA channel. A bus write to a channel's word follows a fixed rule: it keeps only the status bits, clears the chosen event flags, loads the enable and command field, and then settles the stop flag from the run and mask-run bits. The channel engines send single-cycle event pulses (start, end, stop, end-of-receive, request-after-send). Each pulse latches a sticky flag in the word of its channel. The engines also drive a request-pending level per channel, and that level is merged into the read value.

Each channel's flags are combined with their enables into one interrupt condition per channel. The stop, end-of-receive and request-after-send sources are gated by their enables. The start and end flags raise an interrupt with no gating. The per-channel conditions form a status vector, and a single interrupt line is high whenever any bit of that vector is set.

A write of the run bit produces a one-cycle go pulse towards that channel's engine. It also produces a descriptor-fetch pulse, unless no-descriptor-fetch is written in the same word.

Top module: `dmastat_ctrl`

## Requirements
- R1: After reset every channel's word reads 0x00000008 (only the stop flag, bit 3, set), `irq_status` is zero and `irq` is low.
- R2: A full-word write sets the word to (old AND 0x0000071F AND NOT(data AND 0x00000207)) OR (data AND 0xFC800000), before the stop and compare adjustments. Writing one to bits 0, 1, 2 or 9 clears that flag, and bits 3, 4 and 10 are not cleared by writing one.
- R3: After a write, the stop flag (bit 3) is cleared if the new word has stop-interrupt-enable (bit 29) set or if the data has run (bit 31) set. It is then set if the data has neither run nor mask-run (bit 22), and this last rule wins.
- R4: A write with bit 24 clears compare status (bit 10), and a write with bit 25 sets it. When both are written, the set wins.
- R5: A full-word write with run=1 gives a one-cycle `ch_go` pulse for that channel in the next cycle. It also gives a `ch_fetch` pulse in that cycle unless bit 30 (no-descriptor-fetch) is also written. `ch_run` shows bit 31 of each word.
- R6: Event pulses set start (bit 1), end (bit 2), stop (bit 3), request-after-send (bit 4) and end-of-receive (bit 9). A stop event also clears run (bit 31). An event in the same cycle as a write to that channel is applied after the write.
- R7: `rd_data` returns the selected channel's word with bit 8 equal to that channel's `req_pend` level, combinationally.
- R8: Each `irq_status` bit is (bit3 AND bit29) OR (bit9 AND bit28) OR (bit4 AND bit23) OR bit1 OR bit2 of that channel's word. `irq` is high exactly when `irq_status` is nonzero.
- R9: A write whose `wr_strb` is not 4'hF is ignored. The word is unchanged and no go or fetch pulse is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe |
| wr_sel | input | SEL_W | Channel addressed by the write |
| wr_strb | input | 4 | Byte enables; only 4'hF is accepted |
| wr_data | input | 32 | Write data |
| rd_sel | input | SEL_W | Channel addressed by the read |
| rd_data | output | 32 | Read value of the selected channel |
| ev_start | input | NUM_CH | Start event pulses |
| ev_end | input | NUM_CH | End event pulses |
| ev_stop | input | NUM_CH | Stop event pulses |
| ev_eor | input | NUM_CH | End-of-receive event pulses |
| ev_ras | input | NUM_CH | Request-after-send event pulses |
| req_pend | input | NUM_CH | Request-pending levels |
| ch_run | output | NUM_CH | Run bit of each channel |
| ch_go | output | NUM_CH | One-cycle start pulse per channel |
| ch_fetch | output | NUM_CH | One-cycle descriptor-fetch pulse per channel |
| irq_status | output | NUM_CH | Combined interrupt status vector |
| irq | output | 1 | Interrupt line |

## Verification
Some rules are checked by assertions on every cycle:
- a stop event leaves the stop flag set and run clear,
- a run write clears the stop flag,
- a write with neither run nor mask-run sets it,
- a compare-set write sets compare status,
- a run write is followed by a go pulse,
- a word with no write and no event holds its value,
- a start event raises the interrupt line.

Other behaviour can only be shown by the bench's scenarios, which compare every word against an independent model:
- the exact masking of a write,
- which bits clear when one is written to them,
- the order of write and event in the same cycle,
- the fetch pulse being held back by no-descriptor-fetch,
- the merging of the request level into the read value,
- the gating of each interrupt source.

// File: rtl/dmastat_pkg.sv
package dmastat_pkg;

   localparam int CSR_W = 32;

   // status field positions
   localparam int B_ERR    = 0;
   localparam int B_START  = 1;
   localparam int B_END    = 2;
   localparam int B_STOP   = 3;
   localparam int B_RAS    = 4;
   localparam int B_REQ    = 8;
   localparam int B_EOR    = 9;
   localparam int B_CMP    = 10;
   // control field positions
   localparam int B_MRUN    = 22;
   localparam int B_RASEN   = 23;
   localparam int B_CMPCLR  = 24;
   localparam int B_CMPSET  = 25;
   localparam int B_EORSTOP = 26;
   localparam int B_EORJMP  = 27;
   localparam int B_EOREN   = 28;
   localparam int B_STOPEN  = 29;
   localparam int B_NOFETCH = 30;
   localparam int B_RUN     = 31;

   localparam logic [CSR_W-1:0] KEEP_MASK = 32'h0000_071F;
   localparam logic [CSR_W-1:0] W1C_MASK  = 32'h0000_0207;
   localparam logic [CSR_W-1:0] CTL_MASK  = 32'hFC80_0000;
   localparam logic [CSR_W-1:0] CSR_RST   = 32'h0000_0008;

   typedef struct packed {
      logic stop;
      logic eor;
      logic ras;
      logic start;
      logic fin;
   } irq_src_t;

   // bus write rule: mask, clear-by-one, load control, then stop/compare fixups
   function automatic logic [CSR_W-1:0] csr_apply(input logic [CSR_W-1:0] old_v,
                                                  input logic [CSR_W-1:0] wd);
      logic [CSR_W-1:0] n;
      n = (old_v & KEEP_MASK & ~(wd & W1C_MASK)) | (wd & CTL_MASK);
      if (n[B_STOPEN])               n[B_STOP] = 1'b0;
      if (wd[B_RUN])                 n[B_STOP] = 1'b0;
      if (!wd[B_RUN] && !wd[B_MRUN]) n[B_STOP] = 1'b1;
      if (wd[B_CMPCLR])              n[B_CMP]  = 1'b0;
      if (wd[B_CMPSET])              n[B_CMP]  = 1'b1;
      n[B_REQ] = 1'b0;
      return n;
   endfunction

endpackage

// File: rtl/dmastat_chan.sv
module dmastat_chan
   import dmastat_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_hit,
   input  logic [CSR_W-1:0] wr_data,
   input  logic             ev_start,
   input  logic             ev_end,
   input  logic             ev_stop,
   input  logic             ev_eor,
   input  logic             ev_ras,
   output logic [CSR_W-1:0] csr_q,
   output irq_src_t         src,
   output logic             go_p,
   output logic             fetch_p
);

   logic [CSR_W-1:0] csr_d;

   always_comb begin
      csr_d = csr_q;
      if (wr_hit) csr_d = csr_apply(csr_q, wr_data);
      // engine events land after the bus update
      if (ev_start) csr_d[B_START] = 1'b1;
      if (ev_end)   csr_d[B_END]   = 1'b1;
      if (ev_eor)   csr_d[B_EOR]   = 1'b1;
      if (ev_ras)   csr_d[B_RAS]   = 1'b1;
      if (ev_stop) begin
         csr_d[B_STOP] = 1'b1;
         csr_d[B_RUN]  = 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         csr_q   <= CSR_RST;
         go_p    <= 1'b0;
         fetch_p <= 1'b0;
      end else begin
         csr_q   <= csr_d;
         go_p    <= wr_hit & wr_data[B_RUN];
         fetch_p <= wr_hit & wr_data[B_RUN] & ~wr_data[B_NOFETCH];
      end
   end

   always_comb begin
      src.stop  = csr_q[B_STOP] & csr_q[B_STOPEN];
      src.eor   = csr_q[B_EOR]  & csr_q[B_EOREN];
      src.ras   = csr_q[B_RAS]  & csr_q[B_RASEN];
      src.start = csr_q[B_START];
      src.fin   = csr_q[B_END];
   end

   p_stop_event_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ev_stop |=> (csr_q[B_STOP] && !csr_q[B_RUN]));
   p_run_clears_stop_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_hit && wr_data[B_RUN] && !ev_stop) |=> !csr_q[B_STOP]);
   p_halt_sets_stop_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_hit && !wr_data[B_RUN] && !wr_data[B_MRUN]) |=> csr_q[B_STOP]);
   p_cmp_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_hit && wr_data[B_CMPSET]) |=> csr_q[B_CMP]);
   p_go_after_run_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_hit && wr_data[B_RUN]) |=> go_p);
   p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_hit && !ev_start && !ev_end && !ev_stop && !ev_eor && !ev_ras)
      |=> $stable(csr_q));

endmodule

// File: rtl/dmastat_irq.sv
module dmastat_irq
   import dmastat_pkg::*;
#(
   parameter int NUM_CH = 16
) (
   input  irq_src_t          src [NUM_CH],
   output logic [NUM_CH-1:0] status,
   output logic              irq
);

   for (genvar c = 0; c < NUM_CH; c++) begin : g_or
      assign status[c] = src[c].stop | src[c].eor | src[c].ras |
                         src[c].start | src[c].fin;
   end

   assign irq = |status;

endmodule

// File: rtl/dmastat_rdmux.sv
module dmastat_rdmux
   import dmastat_pkg::*;
#(
   parameter int NUM_CH = 16,
   localparam int SEL_W = $clog2(NUM_CH)
) (
   input  logic [CSR_W-1:0] csr [NUM_CH],
   input  logic [NUM_CH-1:0] req_pend,
   input  logic [SEL_W-1:0]  rd_sel,
   output logic [CSR_W-1:0]  rd_val
);

   always_comb begin
      rd_val = '0;
      for (int c = 0; c < NUM_CH; c++) begin
         if (rd_sel == SEL_W'(c)) begin
            rd_val        = csr[c];
            rd_val[B_REQ] = req_pend[c];
         end
      end
   end

endmodule

// File: rtl/dmastat_ctrl.sv
module dmastat_ctrl
   import dmastat_pkg::*;
#(
   parameter int NUM_CH   = 16,
   parameter bit READ_REG = 1'b0,
   localparam int SEL_W   = $clog2(NUM_CH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [SEL_W-1:0]  wr_sel,
   input  logic [3:0]        wr_strb,
   input  logic [31:0]       wr_data,
   input  logic [SEL_W-1:0]  rd_sel,
   output logic [31:0]       rd_data,
   input  logic [NUM_CH-1:0] ev_start,
   input  logic [NUM_CH-1:0] ev_end,
   input  logic [NUM_CH-1:0] ev_stop,
   input  logic [NUM_CH-1:0] ev_eor,
   input  logic [NUM_CH-1:0] ev_ras,
   input  logic [NUM_CH-1:0] req_pend,
   output logic [NUM_CH-1:0] ch_run,
   output logic [NUM_CH-1:0] ch_go,
   output logic [NUM_CH-1:0] ch_fetch,
   output logic [NUM_CH-1:0] irq_status,
   output logic              irq
);

   if (NUM_CH < 2 || NUM_CH > 32) begin : g_bad_cfg
      $error("dmastat_ctrl: NUM_CH must lie in 2..32");
   end

   logic             full_wr;
   logic [CSR_W-1:0] csr_v [NUM_CH];
   irq_src_t         src_v [NUM_CH];
   logic [CSR_W-1:0] rd_val;

   assign full_wr = wr_en && (wr_strb == 4'hF);

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      dmastat_chan u_chan (
         .clk      (clk),
         .rst_n    (rst_n),
         .wr_hit   (full_wr && (wr_sel == SEL_W'(c))),
         .wr_data  (wr_data),
         .ev_start (ev_start[c]),
         .ev_end   (ev_end[c]),
         .ev_stop  (ev_stop[c]),
         .ev_eor   (ev_eor[c]),
         .ev_ras   (ev_ras[c]),
         .csr_q    (csr_v[c]),
         .src      (src_v[c]),
         .go_p     (ch_go[c]),
         .fetch_p  (ch_fetch[c])
      );
      assign ch_run[c] = csr_v[c][B_RUN];
   end

   dmastat_irq #(.NUM_CH(NUM_CH)) u_irq (
      .src    (src_v),
      .status (irq_status),
      .irq    (irq)
   );

   dmastat_rdmux #(.NUM_CH(NUM_CH)) u_rdmux (
      .csr      (csr_v),
      .req_pend (req_pend),
      .rd_sel   (rd_sel),
      .rd_val   (rd_val)
   );

   if (READ_REG) begin : g_rd_reg
      always_ff @(posedge clk) begin
         if (!rst_n) rd_data <= '0;
         else        rd_data <= rd_val;
      end
   end else begin : g_rd_comb
      assign rd_data = rd_val;
   end

   p_start_raises_irq_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (|ev_start) |=> irq);
   p_narrow_no_go_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_strb != 4'hF) |=> (ch_go == '0));

endmodule

// File: tb/dmastat_ctrl_tb.sv
`timescale 1ns/10ps
module dmastat_ctrl_tb_top;

   localparam int NC = 16;
   localparam int SW = $clog2(NC);

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_en = 1'b0;
   logic [SW-1:0] wr_sel = '0;
   logic [3:0]    wr_strb = 4'h0;
   logic [31:0]   wr_data = '0;
   logic [SW-1:0] rd_sel = '0;
   logic [31:0]   rd_data;
   logic [NC-1:0] ev_start = '0, ev_end = '0, ev_stop = '0, ev_eor = '0, ev_ras = '0;
   logic [NC-1:0] req_pend = '0;
   logic [NC-1:0] ch_run, ch_go, ch_fetch, irq_status;
   logic          irq;

   always #10 clk = ~clk;

   dmastat_ctrl #(.NUM_CH(NC)) dut_i (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_strb(wr_strb),
      .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data),
      .ev_start(ev_start), .ev_end(ev_end), .ev_stop(ev_stop), .ev_eor(ev_eor),
      .ev_ras(ev_ras), .req_pend(req_pend), .ch_run(ch_run), .ch_go(ch_go),
      .ch_fetch(ch_fetch), .irq_status(irq_status), .irq(irq)
   );

   int checks = 0;
   int errors = 0;
   string tag = "R1";

   logic [31:0]   mdl [NC];
   logic [NC-1:0] exp_go = '0, exp_fetch = '0;

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%08h expected=%08h at %0t", req, act, exp, $time);
      end
   endtask

   // reference model advanced once per rising edge from the driven inputs
   task automatic model_step();
      logic [31:0] n;
      int s;
      exp_go = '0;
      exp_fetch = '0;
      if (!rst_n) begin
         for (int c = 0; c < NC; c++) mdl[c] = 32'h8;
         return;
      end
      if (wr_en && wr_strb == 4'hF) begin
         s = int'(wr_sel);
         n = mdl[s] & 32'h0000_071F;
         n = n & ~(wr_data & 32'h0000_0207);
         n = n | (wr_data & 32'hFC80_0000);
         if (n[29]) n[3] = 1'b0;
         if (wr_data[31]) begin
            n[3] = 1'b0;
            exp_go[s] = 1'b1;
            exp_fetch[s] = !wr_data[30];
         end
         if (!wr_data[31] && !wr_data[22]) n[3] = 1'b1;
         if (wr_data[24]) n[10] = 1'b0;
         if (wr_data[25]) n[10] = 1'b1;
         mdl[s] = n;
      end
      for (int c = 0; c < NC; c++) begin
         if (ev_start[c]) mdl[c][1] = 1'b1;
         if (ev_end[c])   mdl[c][2] = 1'b1;
         if (ev_ras[c])   mdl[c][4] = 1'b1;
         if (ev_eor[c])   mdl[c][9] = 1'b1;
         if (ev_stop[c]) begin mdl[c][3] = 1'b1; mdl[c][31] = 1'b0; end
      end
   endtask

   task automatic compare_all();
      logic [NC-1:0] est, erun;
      logic [31:0] w;
      for (int c = 0; c < NC; c++) begin
         w = mdl[c];
         est[c] = (w[3] & w[29]) | (w[9] & w[28]) | (w[4] & w[23]) | w[1] | w[2];
         erun[c] = w[31];
         rd_sel = SW'(c);
         #0.1;
         w[8] = req_pend[c];
         chk(tag, rd_data, w);
      end
      chk("R8", 32'(irq_status), 32'(est));
      chk("R8", 32'(irq), 32'(est != '0));
      chk("R5", 32'(ch_go), 32'(exp_go));
      chk("R5", 32'(ch_fetch), 32'(exp_fetch));
      chk("R5", 32'(ch_run), 32'(erun));
   endtask

   task automatic tick();
      @(posedge clk);
      model_step();
      @(negedge clk);
      compare_all();
      wr_en = 1'b0;
      ev_start = '0; ev_end = '0; ev_stop = '0; ev_eor = '0; ev_ras = '0;
   endtask

   task automatic wr(input int ch, input logic [31:0] d, input logic [3:0] st = 4'hF);
      wr_en = 1'b1; wr_sel = SW'(ch); wr_data = d; wr_strb = st;
   endtask

   initial begin
      #(20 * 150000);
      errors++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      @(negedge clk); tick(); tick();
      rst_n = 1'b1;
      tag = "R1"; tick();
      // R6: every event kind on channel 2
      tag = "R6";
      ev_start[2] = 1; ev_end[2] = 1; ev_eor[2] = 1; ev_ras[2] = 1; tick();
      // R2: clear-by-one on 0,1,2,9 only; bits 3,4 survive
      tag = "R2"; wr(2, 32'h0000_071F | (1 << 22)); tick();
      wr(2, 32'hFC80_0000); tick();
      wr(2, 32'h0000_0000); tick();
      // R3: stop enable with mask-run clears stop; run clears; halt sets
      tag = "R3"; wr(3, (1 << 29) | (1 << 22)); tick();
      wr(3, (1 << 29)); tick();
      wr(3, 32'h8000_0000); tick(); tick();
      wr(3, 32'h0); tick();
      // R4: compare status set, clear, both
      tag = "R4"; wr(4, (1 << 25) | (1 << 22)); tick();
      wr(4, (1 << 24) | (1 << 22)); tick();
      wr(4, (3 << 24) | (1 << 22)); tick();
      // R5: run with and without no-descriptor-fetch
      tag = "R5"; wr(5, 32'h8000_0000); tick(); tick();
      wr(6, 32'hC000_0000); tick();
      // R6: write and event in same cycle
      tag = "R6"; wr(7, 32'h8000_0207); ev_start[7] = 1; tick();
      wr(7, 32'h8000_0000); ev_stop[7] = 1; tick();
      // R7: request pending levels
      tag = "R7"; req_pend = 16'hA5A5; tick(); req_pend = 16'h0F0F; tick(); req_pend = '0;
      // R8: gated sources
      tag = "R8"; ev_ras[8] = 1; tick(); wr(8, (1 << 23) | (1 << 22)); tick();
      ev_eor[9] = 1; tick(); wr(9, (1 << 28) | (1 << 22)); tick();
      wr(9, (1 << 28) | (1 << 22) | 32'h200); tick();
      // R9: narrow writes ignored
      tag = "R9"; wr(10, 32'hFFFF_FFFF, 4'h7); tick();
      wr(10, 32'hFFFF_FFFF, 4'h0); tick(); wr(11, 32'h8000_0000, 4'hE); tick();
      // mixed traffic
      tag = "R2";
      for (int i = 0; i < 600; i++) begin
         if ($urandom_range(0, 1) == 1)
            wr(int'($urandom_range(0, NC - 1)), $urandom(),
               ($urandom_range(0, 3) == 0) ? 4'($urandom()) : 4'hF);
         ev_start = NC'($urandom() & $urandom());
         ev_end   = NC'($urandom() & $urandom());
         ev_stop  = NC'($urandom() & $urandom() & $urandom());
         ev_eor   = NC'($urandom() & $urandom());
         ev_ras   = NC'($urandom() & $urandom());
         req_pend = NC'($urandom());
         tick();
      end
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule